// File: doc/BRIEF.md
# SDRAM Read-Burst Turnaround Sequencer

This block sits on the controller side of a single-data-rate SDRAM with a 32-bit data bus and four banks. It takes a stream of column-level requests (read, write, precharge of one bank, precharge of all banks) to rows that are already open. It turns each request into a command on the memory command bus one clock later. Idle clocks carry a no-operation command. Row activation, refresh, initialization and analog timing belong to other blocks.

Read bursts are four words long and start CAS-latency clocks after their command. The CAS latency is two or three, chosen by a static pin. A later read cuts a running burst short, and so does a precharge of that bank or of all banks. Before a write can follow a read, the block raises all byte masks early enough to silence the memory's remaining read words. It also leaves one clock with nobody driving the data bus before the write. While this lead time is being enforced it holds the write request back. The block drives the byte masks and the data-bus output enable, and it flags each clock in which the memory is driving an unmasked read word.

The request port is valid/ready. A request is taken on a rising edge where both are high. Once the requester raises `req_valid`, it holds the request fields steady until the request is taken. `req_ready` depends on the block's state and on `req_op`. It is low only while the offered request is a write that must wait for the turnaround. Reads and precharges are never held back. Requests are issued in arrival order.

Top module: `sdr_turn_seq`

## Requirements
- R1: While reset is active and on the first clock after it, the command bus carries no-operation, the byte masks are 0, `dq_oe` and `rd_valid` are 0, and `req_ready` is 1.
- R2: A request taken at a clock edge appears on `mem_cmd`/`mem_ba`/`mem_addr` for exactly the next clock. Every other clock carries no-operation.
  - The command encodings on `mem_cmd`, written as {cs_n, ras_n, cas_n, we_n}, are: no-operation 0111, read 0101, write 0100, precharge 0010.
  - `mem_addr` holds the column in its low bits for reads and writes. Bit 10 is 0 for reads, writes and single-bank precharge, and 1 for precharge of all banks. `req_op` is 0 for read, 1 for write, 2 for single-bank precharge and 3 for all-bank precharge.
- R3: A read command at clock T, with CAS latency 2 (`cl_long`=0) or 3 (`cl_long`=1), gives `rd_valid` high on clocks T+CL to T+CL+3. This holds unless the burst is cut short or masked.
- R4: A read issued on any clock after an earlier read replaces the earlier burst's words from its own T+CL onward. Earlier words before that point stay valid.
- R5: A precharge at clock P removes the running burst's words from P+CL onward when it targets the bank of the last read or all banks. A precharge of any other bank leaves the burst untouched.
- R6: While a write request is held back, all byte masks are driven to 1 on the following clock. Masks are 0 on the write command clock, and a read word whose masks were 1 two clocks earlier is not flagged valid.
- R7: No read word is on the bus in the clock before a write command, in the write command clock, or in the clock after it. Read words due two or more clocks after the write are dropped.
- R8: `dq_oe` is high for the four clocks starting at a write command. A read or precharge command ends it from its own clock, a later write restarts the four clocks, and `dq_oe` is never high in a clock where a read word is on the bus.
- R9: A write is held back no longer than needed. With CL 2, a write offered right behind a read is issued 4 clocks after the read after 3 clocks of back-pressure. With CL 3 it is issued on the next clock, and after two idle clocks it is issued 6 clocks after the read. Reads and precharges are taken on the clock they are offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cl_long | input | 1 | CAS latency select: 0 for 2, 1 for 3; changed only while idle |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this clock |
| req_op | input | 2 | 0 read, 1 write, 2 precharge bank, 3 precharge all |
| req_bank | input | 2 | Target bank |
| req_col | input | 8 | Column address for read and write |
| mem_cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} to the memory |
| mem_ba | output | 2 | Bank address to the memory |
| mem_addr | output | 11 | Address bus to the memory (bit 10 all-bank / auto-precharge flag) |
| mem_dqm | output | 4 | Byte masks to the memory |
| dq_oe | output | 1 | Controller drives the data bus this clock |
| rd_valid | output | 1 | The memory drives an unmasked read word this clock |

## Verification
The assertions assume that `cl_long` changes only while no burst is in flight, since the read-word window is computed with the latency at the time of the command. They also assume that a requester keeps `req_op` and its fields unchanged while a write is held back, because the mask and stall properties tie `req_ready` to the offered operation. The stimulus changes the latency only after long idle stretches and drives each request from one falling edge until it is taken. The bench's memory model rebuilds the bus occupancy from the observed commands and masks. It then compares that occupancy with `rd_valid` and `dq_oe` on every clock.

// File: rtl/sdr_turn_pkg.sv
package sdr_turn_pkg;

  typedef enum logic [1:0] {
    OP_RD     = 2'd0,
    OP_WR     = 2'd1,
    OP_PRE    = 2'd2,
    OP_PREALL = 2'd3
  } req_op_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_RD  = 4'b0101;
  localparam logic [3:0] CMD_WR  = 4'b0100;
  localparam logic [3:0] CMD_PRE = 4'b0010;

endpackage

// File: rtl/sdr_rd_track.sv
// Tracks which future clocks carry read words from the memory, and which of
// them are masked by byte masks applied two clocks earlier.
module sdr_rd_track #(
  parameter int BURST  = 4,
  parameter int MAX_CL = 3,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cl_long,
  input  logic              iss_rd,
  input  logic              iss_wr,
  input  logic              iss_pre,
  input  logic              iss_pre_all,
  input  logic [BANK_W-1:0] iss_bank,
  input  logic              dqm_now,
  output logic              rd_valid,
  output logic              wr_clear
);
  localparam int DEPTH = MAX_CL + BURST;

  // busy_q[k]: the memory's read pipeline drives a word k clocks from now
  logic [DEPTH-1:0]  busy_q, busy_d;
  logic              dqm_d1, dqm_d2;
  logic [BANK_W-1:0] rd_bank_q;
  logic              cut;
  int                cl;

  always_comb begin
    cl     = cl_long ? 3 : 2;
    cut    = iss_rd | (iss_pre & (iss_pre_all | (iss_bank == rd_bank_q)));
    busy_d = busy_q >> 1;
    for (int k = 0; k < DEPTH; k++) begin
      if (iss_wr && k >= 2) busy_d[k] = 1'b0;
      if (cut && k >= cl) busy_d[k] = iss_rd && (k < cl + BURST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= '0;
      dqm_d1    <= 1'b0;
      dqm_d2    <= 1'b0;
      rd_bank_q <= '0;
    end else begin
      busy_q <= busy_d;
      dqm_d1 <= dqm_now;
      dqm_d2 <= dqm_d1;
      if (iss_rd) rd_bank_q <= iss_bank;
    end
  end

  assign rd_valid = busy_q[0] & ~dqm_d2;
  // write may go next clock: gap clock, write clock and the one after are quiet
  assign wr_clear = ~(busy_q[0] & ~dqm_d2) & ~(busy_q[1] & ~dqm_d1)
                  & ~(busy_q[2] & ~dqm_now);

  // R6: a mask raised now silences the word two clocks later
  p_mask_silences_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dqm_now |=> ##1 !rd_valid);

endmodule

// File: rtl/sdr_wr_window.sv
// Data-bus output enable for the write burst.
module sdr_wr_window #(
  parameter int BURST = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic iss_wr,
  input  logic iss_stop,
  output logic dq_oe
);
  localparam int CW = $clog2(BURST + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (iss_wr)         left_q <= CW'(BURST);
    else if (iss_stop)       left_q <= '0;
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign dq_oe = (left_q != '0);

  // R8: a write always opens the window on the command clock
  p_window_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
    iss_wr |=> dq_oe);

endmodule

// File: rtl/sdr_cmd_issue.sv
// Registers the command, bank, address and byte-mask outputs.
module sdr_cmd_issue
  import sdr_turn_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int ADDR_W = 11,
  parameter int BANK_W = 2,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [1:0]        op,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  input  logic              hold_mask,
  output logic [3:0]        cmd_q,
  output logic [BANK_W-1:0] ba_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              dqm_q
);
  logic [3:0]        cmd_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    if (acc) begin
      unique case (req_op_e'(op))
        OP_RD:     begin cmd_d = CMD_RD; addr_d[COL_W-1:0] = col; end
        OP_WR:     begin cmd_d = CMD_WR; addr_d[COL_W-1:0] = col; end
        OP_PRE:    cmd_d = CMD_PRE;
        OP_PREALL: begin cmd_d = CMD_PRE; addr_d[AP_BIT] = 1'b1; end
        default:   cmd_d = CMD_NOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      dqm_q  <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      ba_q   <= acc ? bank : ba_q;
      addr_q <= addr_d;
      dqm_q  <= hold_mask;
    end
  end

  // R2: with nothing taken, the next clock is a no-operation
  p_idle_nop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> cmd_q == CMD_NOP);

endmodule

// File: rtl/sdr_turn_seq.sv
module sdr_turn_seq
  import sdr_turn_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int ADDR_W = 11,
  parameter int BANK_W = 2,
  parameter int BURST  = 4,
  parameter int MAX_CL = 3,
  parameter int DQM_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cl_long,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  output logic [3:0]        mem_cmd,
  output logic [BANK_W-1:0] mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DQM_W-1:0]  mem_dqm,
  output logic              dq_oe,
  output logic              rd_valid
);
  logic is_wr, wr_clear, acc, hold_mask, dqm_q;
  logic iss_rd, iss_wr, iss_pre, iss_pre_all;

  assign is_wr       = (req_op == OP_WR);
  assign req_ready   = !is_wr || wr_clear;
  assign acc         = req_valid && req_ready;
  assign hold_mask   = req_valid && is_wr && !wr_clear;
  assign iss_rd      = acc && (req_op == OP_RD);
  assign iss_wr      = acc && is_wr;
  assign iss_pre     = acc && (req_op == OP_PRE || req_op == OP_PREALL);
  assign iss_pre_all = acc && (req_op == OP_PREALL);

  sdr_cmd_issue #(
    .COL_W(COL_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .AP_BIT(10)
  ) u_issue (
    .clk(clk), .rst_n(rst_n), .acc(acc), .op(req_op), .bank(req_bank),
    .col(req_col), .hold_mask(hold_mask), .cmd_q(mem_cmd), .ba_q(mem_ba),
    .addr_q(mem_addr), .dqm_q(dqm_q)
  );

  sdr_rd_track #(
    .BURST(BURST), .MAX_CL(MAX_CL), .BANK_W(BANK_W)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .cl_long(cl_long), .iss_rd(iss_rd),
    .iss_wr(iss_wr), .iss_pre(iss_pre), .iss_pre_all(iss_pre_all),
    .iss_bank(req_bank), .dqm_now(dqm_q), .rd_valid(rd_valid),
    .wr_clear(wr_clear)
  );

  sdr_wr_window #(.BURST(BURST)) u_window (
    .clk(clk), .rst_n(rst_n), .iss_wr(iss_wr),
    .iss_stop(iss_rd || iss_pre), .dq_oe(dq_oe)
  );

  assign mem_dqm = {DQM_W{dqm_q}};

  // R8: controller and memory never drive the bus together
  p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !rd_valid);

  // R7: gap clock before the write, quiet write clock and the clock after
  p_gap_before_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd == CMD_WR |-> !$past(rd_valid));
  p_quiet_at_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd == CMD_WR |-> !rd_valid);
  p_quiet_after_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd == CMD_WR |=> !rd_valid);

  // R6: a held write raises every mask on the next clock
  p_stall_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> mem_dqm == {DQM_W{1'b1}});
  p_wr_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd == CMD_WR |-> mem_dqm == '0);

  // R9: back-pressure only ever applies to writes
  p_stall_only_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |-> req_op == OP_WR);

endmodule

// File: tb/test_sdr_turn_seq.sv
`timescale 1ns/1ps
module test_sdr_turn_seq;
  import sdr_turn_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n, cl_long, req_valid, req_ready;
  logic [1:0]  req_op, req_bank;
  logic [7:0]  req_col;
  logic [3:0]  mem_cmd;
  logic [1:0]  mem_ba;
  logic [10:0] mem_addr;
  logic [3:0]  mem_dqm;
  logic        dq_oe, rd_valid;

  always #5 clk = ~clk;

  sdr_turn_seq i_sdr_turn_seq (
    .clk(clk), .rst_n(rst_n), .cl_long(cl_long), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_bank(req_bank),
    .req_col(req_col), .mem_cmd(mem_cmd), .mem_ba(mem_ba),
    .mem_addr(mem_addr), .mem_dqm(mem_dqm), .dq_oe(dq_oe),
    .rd_valid(rd_valid)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected command stream
  logic [3:0]  q_cmd[$];
  logic [1:0]  q_ba[$];
  logic [10:0] q_addr[$];

  // memory-side data bus model, indexed by clock number
  bit sched[256];
  bit dqmh[256];
  int cyc = 0, oe_end = -10, rbank = 0;
  int rv_tot = 0, oe_tot = 0, dqm_tot = 0, last_rd = 0, last_wr = 0;
  bit prev_drv = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int n, cl;
      bit drv;
      n  = cyc;
      cl = cl_long ? 3 : 2;
      if (mem_cmd != CMD_NOP) begin
        if (q_cmd.size() == 0) chk(0, "R2 unexpected command", int'(mem_cmd), int'(CMD_NOP));
        else begin
          logic [3:0] ec; logic [1:0] eb; logic [10:0] ea;
          ec = q_cmd.pop_front(); eb = q_ba.pop_front(); ea = q_addr.pop_front();
          chk(mem_cmd == ec, "R2 command code", int'(mem_cmd), int'(ec));
          chk(mem_ba == eb, "R2 bank", int'(mem_ba), int'(eb));
          chk(mem_addr == ea, "R2 address", int'(mem_addr), int'(ea));
        end
      end
      if (mem_cmd == CMD_RD) begin
        last_rd = n; rbank = int'(mem_ba); oe_end = n - 1;
        for (int j = n + cl; j < n + cl + 8; j++) sched[j % 256] = 0;
        for (int j = n + cl; j < n + cl + 4; j++) sched[j % 256] = 1;
      end else if (mem_cmd == CMD_PRE) begin
        oe_end = n - 1;
        if (mem_addr[10] || int'(mem_ba) == rbank)
          for (int j = n + cl; j < n + cl + 8; j++) sched[j % 256] = 0;
      end else if (mem_cmd == CMD_WR) begin
        last_wr = n; oe_end = n + 3;
        chk(!prev_drv, "R7 gap before write", int'(prev_drv), 0);
        chk(mem_dqm == 4'h0, "R6 masks low at write", int'(mem_dqm), 0);
        for (int j = n + 2; j < n + 10; j++) sched[j % 256] = 0;
      end
      chk(mem_dqm == 4'h0 || mem_dqm == 4'hF, "R6 mask uniform", int'(mem_dqm), 15);
      dqmh[n % 256] = (mem_dqm != 0);
      drv = sched[n % 256] && (n < 2 || !dqmh[(n + 254) % 256]);
      sched[n % 256] = 0;
      chk(rd_valid == drv, "R3 read word flag", int'(rd_valid), int'(drv));
      chk(dq_oe == (n <= oe_end), "R8 output enable", int'(dq_oe), int'(n <= oe_end));
      chk(!(dq_oe && drv), "R8 bus contention", int'(dq_oe), 0);
      rv_tot += int'(rd_valid); oe_tot += int'(dq_oe); dqm_tot += int'(mem_dqm != 0);
      prev_drv = drv;
      cyc++;
    end
  end

  int stall_cnt;

  // called at a falling edge; returns at the falling edge of the command clock
  task automatic send(input logic [1:0] op, input logic [1:0] bank, input logic [7:0] col);
    req_valid = 1; req_op = op; req_bank = bank; req_col = col;
    stall_cnt = 0;
    #1;
    while (!req_ready) begin stall_cnt++; @(negedge clk); #1; end
    case (op)
      2'd0: begin q_cmd.push_back(CMD_RD);  q_addr.push_back({3'b0, col}); end
      2'd1: begin q_cmd.push_back(CMD_WR);  q_addr.push_back({3'b0, col}); end
      2'd2: begin q_cmd.push_back(CMD_PRE); q_addr.push_back(11'h000); end
      default: begin q_cmd.push_back(CMD_PRE); q_addr.push_back(11'h400); end
    endcase
    q_ba.push_back(bank);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int rv0, oe0, dq0;
  task automatic mark();
    rv0 = rv_tot; oe0 = oe_tot; dq0 = dqm_tot;
  endtask

  initial begin
    rst_n = 0; cl_long = 0; req_valid = 0; req_op = 2'd1; req_bank = 0; req_col = 0;
    repeat (3) @(negedge clk);
    chk(mem_cmd == CMD_NOP, "R1 reset command", int'(mem_cmd), int'(CMD_NOP));
    chk(mem_dqm == 0 && !dq_oe && !rd_valid, "R1 reset outputs", int'({mem_dqm, dq_oe, rd_valid}), 0);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk(req_ready == 1, "R1 ready after reset", int'(req_ready), 1);
    chk(mem_cmd == CMD_NOP, "R1 idle after reset", int'(mem_cmd), int'(CMD_NOP));
    idle(2);

    // R3 single bursts at both latencies
    mark(); send(2'd0, 2'd1, 8'h10); idle(12);
    chk(rv_tot - rv0 == 4, "R3 CL2 burst words", rv_tot - rv0, 4);
    cl_long = 1; idle(2);
    mark(); send(2'd0, 2'd2, 8'h20); idle(12);
    chk(rv_tot - rv0 == 4, "R3 CL3 burst words", rv_tot - rv0, 4);
    cl_long = 0; idle(2);

    // R4 read cut by read
    mark(); send(2'd0, 2'd0, 8'h01); idle(1); send(2'd0, 2'd3, 8'h02); idle(12);
    chk(rv_tot - rv0 == 6, "R4 read after one gap", rv_tot - rv0, 6);
    mark(); send(2'd0, 2'd0, 8'h03); send(2'd0, 2'd0, 8'h04); idle(12);
    chk(rv_tot - rv0 == 5, "R4 back to back reads", rv_tot - rv0, 5);

    // R5 precharge
    mark(); send(2'd0, 2'd1, 8'h05); send(2'd2, 2'd1, 8'h00); idle(12);
    chk(rv_tot - rv0 == 1, "R5 same bank precharge", rv_tot - rv0, 1);
    mark(); send(2'd0, 2'd1, 8'h06); send(2'd2, 2'd2, 8'h00); idle(12);
    chk(rv_tot - rv0 == 4, "R5 other bank precharge", rv_tot - rv0, 4);
    cl_long = 1; idle(2);
    mark(); send(2'd0, 2'd3, 8'h07); send(2'd3, 2'd0, 8'h00); idle(12);
    chk(rv_tot - rv0 == 1, "R5 all bank precharge", rv_tot - rv0, 1);
    cl_long = 0; idle(2);

    // R6 R7 R9 read then write, CL 2
    mark(); send(2'd0, 2'd0, 8'h11);
    chk(stall_cnt == 0, "R9 read not held", stall_cnt, 0);
    send(2'd1, 2'd0, 8'h12);
    chk(stall_cnt == 3, "R9 write held clocks", stall_cnt, 3);
    idle(12);
    chk(last_wr - last_rd == 4, "R9 CL2 write spacing", last_wr - last_rd, 4);
    chk(rv_tot - rv0 == 1, "R7 CL2 words before write", rv_tot - rv0, 1);
    chk(dqm_tot - dq0 == 3, "R6 masked clocks", dqm_tot - dq0, 3);

    // CL 3 cases
    cl_long = 1; idle(2);
    mark(); send(2'd0, 2'd2, 8'h13); send(2'd1, 2'd2, 8'h14); idle(12);
    chk(last_wr - last_rd == 1, "R9 CL3 immediate write", last_wr - last_rd, 1);
    chk(rv_tot - rv0 == 0, "R7 CL3 words dropped", rv_tot - rv0, 0);
    mark(); send(2'd0, 2'd2, 8'h15); idle(2); send(2'd1, 2'd1, 8'h16); idle(12);
    chk(last_wr - last_rd == 6, "R9 CL3 delayed write", last_wr - last_rd, 6);
    chk(rv_tot - rv0 == 2, "R7 CL3 words kept", rv_tot - rv0, 2);
    cl_long = 0; idle(2);

    // R8 output enable window
    mark(); send(2'd1, 2'd0, 8'h21); idle(1); send(2'd0, 2'd0, 8'h22); idle(12);
    chk(oe_tot - oe0 == 2, "R8 read ends write window", oe_tot - oe0, 2);
    mark(); send(2'd1, 2'd0, 8'h23); send(2'd1, 2'd1, 8'h24); idle(12);
    chk(oe_tot - oe0 == 5, "R8 write restarts window", oe_tot - oe0, 5);
    mark(); send(2'd1, 2'd2, 8'h25); idle(12);
    chk(oe_tot - oe0 == 4, "R8 full write window", oe_tot - oe0, 4);

    chk(q_cmd.size() == 0, "R2 all requests issued", q_cmd.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule